// File: doc/BRIEF.md
# Tuner Control Serial Slave

This block is the two-wire serial (I2C) slave of a tuning synthesiser. A bus master writes tuning and control settings into it and reads back one status byte. The block samples SCL and SDA with its own system clock, finds START and STOP conditions, and answers a 7-bit address. The five upper bits of that address are a parameter. The two low bits come from a select input, so up to four of these slaves can share one bus. SDA is driven only as an open-drain pull-down enable.

In a write transfer each data byte is routed by its most significant bit. A byte with MSB 0 opens a frequency pair. Its low seven bits and all eight bits of the byte that follows form a 15-bit divide ratio, and the divider sees the ratio as one value once the second byte is complete. A byte with MSB 1 is a control byte. It carries the charge-pump current, test-mode, pump-disable and amplifier-off bits, and the byte after it sets the eight port enables. Any number of pairs may follow one address. No register changes until all eight bits of its byte have arrived, so a byte cut short by STOP or by a repeated START leaves the old value in place.

In a read transfer the slave sends a status byte. It holds a sticky power-on flag, the lock flag, three port input levels and a 3-bit ADC code. The slave sends another status byte each time the master acknowledges, and stops on a not-acknowledge. The power-on flag is set by reset. It clears only when a read transfer is closed by STOP.

Top module: `tuner_i2c_slave`

## Requirements
- R1: The slave pulls SDA low in the acknowledge slot only when the received address equals {ADDR_HI, addrSel}. Any other address gets no acknowledge and changes nothing. Bit 0 of the address byte selects read when it is 1 and write when it is 0.
- R2: A write data byte with MSB 0 opens a frequency pair. When the byte after it completes, divRatio becomes {first[6:0], second[7:0]}. divRatio does not change at any other time.
- R3: A write data byte with MSB 1 is a control byte. Counting byte bit 7 as the MSB, it loads cpHigh from bit 6, testMode from bit 5, cpDisable from bit 4 and ampOff from bit 0.
- R4: The byte that follows a control byte is loaded whole into portReg (1 = port on, 0 = high impedance). portReg changes only when such a byte completes.
- R5: Several pairs of either kind may follow one address in the same transfer, and each pair takes effect.
- R6: A STOP that comes before the eighth bit of a byte leaves every register unchanged and returns the slave to idle.
- R7: The status byte is sent MSB first as {por, lockIn, portLevels[2:0], adcCode[2:0]}. portLevels[2] is P7, portLevels[1] is P5 and portLevels[0] is P4.
- R8: The power-on flag is 1 after reset. A write transfer ending in STOP leaves it set. A read transfer ending in STOP clears it.
- R9: In read mode, a master acknowledge (SDA low in the ninth slot) makes the slave send a fresh status byte. A not-acknowledge makes it release SDA and send nothing more.
- R10: After reset, divRatio, cpHigh, testMode, cpDisable, ampOff and portReg are all 0, so all ports are high impedance.
- R11: A repeated START restarts address decoding and pair tracking. The first data byte after it is always taken as the first byte of a pair.
- R12: In a write transfer the slave acknowledges every complete data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullDown | output | 1 | 1 pulls SDA low (open-drain enable) |
| addrSel | input | 2 | Low two address bits |
| lockIn | input | 1 | Phase-lock flag from the loop |
| portLevels | input | 3 | Input levels of P7, P5, P4 |
| adcCode | input | 3 | Code from the 5-level ADC |
| divRatio | output | 15 | Divide ratio for the programmable divider |
| cpHigh | output | 1 | Charge-pump high current |
| testMode | output | 1 | Phase-comparator test routing |
| cpDisable | output | 1 | Charge pump disabled |
| ampOff | output | 1 | Drive amplifier off |
| portReg | output | 8 | Port on/off enables |

## Verification
Two functions can fall in the same cycle: the bus-condition detector closing a transfer, and the datapath committing a byte or clearing the power-on flag. The bench provokes this by issuing STOP after four bits of a port byte and of a second frequency byte. It then judges that portReg and divRatio keep their old values. It also closes one write transfer and one read transfer with STOP, and reads the power-on flag back through the status byte. After the write it must still be set, and after the read it must be clear.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDATA, S_WACK, S_RDATA, S_RACK
  } busState_t;

  typedef struct packed {
    logic sampleBit;   // shift sdaBit into the receive register
    logic sdaBit;      // sampled data line
    logic byteDone;    // a write data byte is complete
    logic secondByte;  // that byte is the second of a pair
    logic loadTx;      // capture a fresh status byte
    logic shiftTx;     // advance the status byte by one bit
    logic clearPor;    // a read transfer ended with STOP
  } dpStrobes_t;
endpackage

// File: rtl/tuner_i2c_ctrl.sv
module tuner_i2c_ctrl
  import tuner_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b11000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [1:0]       addrSel,
  input  logic [BYTE_W-1:0] rxByte,
  output dpStrobes_t       str,
  output logic             ackDrive,
  output logic             txActive,
  output logic             stopSeen
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclNow, sdaNow;
  logic sclRise, sclFall, startSeen;
  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic byteFull, secondNext, isRead, readSeen, ackBit;
  logic [6:0] myAddr;

  assign myAddr = {ADDR_HI, addrSel};
  assign sclNow = sclSync[1];
  assign sdaNow = sdaSync[1];
  assign sclRise = sclNow & ~sclPrev;
  assign sclFall = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11; sdaSync <= 2'b11;
      sclPrev <= 1'b1;  sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; bitCnt <= '0; byteFull <= 1'b0;
      secondNext <= 1'b0; isRead <= 1'b0; readSeen <= 1'b0; ackBit <= 1'b1;
    end else if (startSeen) begin
      state <= S_ADDR; bitCnt <= '0; byteFull <= 1'b0;
      secondNext <= 1'b0; readSeen <= 1'b0;
    end else if (stopSeen) begin
      state <= S_IDLE; bitCnt <= '0; byteFull <= 1'b0;
    end else if (sclRise) begin
      if (state == S_ADDR || state == S_WDATA || state == S_RDATA) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == CNT_W'(BYTE_W - 1)) byteFull <= 1'b1;
      end
      if (state == S_RACK) ackBit <= sdaNow;
    end else if (sclFall) begin
      case (state)
        S_ADDR: if (byteFull) begin
          byteFull <= 1'b0;
          if (rxByte[7:1] == myAddr) begin
            state <= S_AACK; isRead <= rxByte[0]; readSeen <= rxByte[0];
          end else begin
            state <= S_IDLE;
          end
        end
        S_AACK:  state <= isRead ? S_RDATA : S_WDATA;
        S_WDATA: if (byteFull) begin
          byteFull <= 1'b0; state <= S_WACK; secondNext <= ~secondNext;
        end
        S_WACK:  state <= S_WDATA;
        S_RDATA: if (byteFull) begin
          byteFull <= 1'b0; state <= S_RACK;
        end
        S_RACK:  state <= ackBit ? S_IDLE : S_RDATA;
        default: state <= state;
      endcase
    end
  end

  always_comb begin
    str = '0;
    str.sdaBit     = sdaNow;
    str.sampleBit  = sclRise & (state == S_ADDR || state == S_WDATA);
    str.byteDone   = sclFall & ~startSeen & ~stopSeen & (state == S_WDATA) & byteFull;
    str.secondByte = secondNext;
    str.loadTx     = sclFall & ~startSeen & ~stopSeen &
                     (((state == S_AACK) & isRead) | ((state == S_RACK) & ~ackBit));
    str.shiftTx    = sclFall & (state == S_RDATA) & ~byteFull;
    str.clearPor   = stopSeen & readSeen;
  end

  assign ackDrive = (state == S_AACK) || (state == S_WACK);
  assign txActive = (state == S_RDATA);

  // R1: the address acknowledge follows only a matching address byte
  assert_ack_needs_match_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_AACK && $past(state) == S_ADDR) |-> $past(rxByte[7:1] == myAddr));
  // R6: STOP always ends the transfer
  assert_stop_goes_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> state == S_IDLE);
  // R9: a not-acknowledge ends the read
  assert_nack_ends_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RACK && sclFall && ackBit && !startSeen && !stopSeen) |=> state == S_IDLE);
endmodule

// File: rtl/tuner_i2c_dp.sv
module tuner_i2c_dp
  import tuner_i2c_pkg::*;
#(
  parameter int DIV_W = 2 * BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        str,
  input  logic              lockIn,
  input  logic [2:0]        portLevels,
  input  logic [2:0]        adcCode,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit,
  output logic [DIV_W-1:0]  divRatio,
  output logic              cpHigh,
  output logic              testMode,
  output logic              cpDisable,
  output logic              ampOff,
  output logic [BYTE_W-1:0] portReg,
  output logic              porFlag
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic [HI_W-1:0]   freqHi;
  logic              pairIsCtrl;
  logic [BYTE_W-1:0] txReg;

  assign txBit = txReg[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0; txReg <= '0; freqHi <= '0; pairIsCtrl <= 1'b0;
      divRatio <= '0; cpHigh <= 1'b0; testMode <= 1'b0; cpDisable <= 1'b0;
      ampOff <= 1'b0; portReg <= '0; porFlag <= 1'b1;
    end else begin
      if (str.sampleBit) rxByte <= {rxByte[BYTE_W-2:0], str.sdaBit};
      if (str.byteDone && !str.secondByte) begin
        pairIsCtrl <= rxByte[BYTE_W-1];
        if (rxByte[BYTE_W-1]) begin
          cpHigh    <= rxByte[6];
          testMode  <= rxByte[5];
          cpDisable <= rxByte[4];
          ampOff    <= rxByte[0];
        end else begin
          freqHi <= rxByte[HI_W-1:0];
        end
      end
      if (str.byteDone && str.secondByte) begin
        if (pairIsCtrl) portReg  <= rxByte;
        else            divRatio <= {freqHi, rxByte};
      end
      if (str.loadTx)       txReg <= {porFlag, lockIn, portLevels, adcCode};
      else if (str.shiftTx) txReg <= {txReg[BYTE_W-2:0], 1'b0};
      if (str.clearPor) porFlag <= 1'b0;
    end
  end

  // R2: the ratio moves only when a second pair byte completes
  assert_ratio_on_second_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divRatio) |-> $past(str.byteDone && str.secondByte));
  // R4: the port register moves only when a second pair byte completes
  assert_ports_on_second_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(portReg) |-> $past(str.byteDone && str.secondByte));
endmodule

// File: rtl/tuner_i2c_slave.sv
module tuner_i2c_slave
  import tuner_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_HI = 5'b11000,
  parameter int         DIV_W   = 2 * BYTE_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullDown,
  input  logic [1:0]        addrSel,
  input  logic              lockIn,
  input  logic [2:0]        portLevels,
  input  logic [2:0]        adcCode,
  output logic [DIV_W-1:0]  divRatio,
  output logic              cpHigh,
  output logic              testMode,
  output logic              cpDisable,
  output logic              ampOff,
  output logic [BYTE_W-1:0] portReg
);
  dpStrobes_t        str;
  logic [BYTE_W-1:0] rxByte;
  logic ackDrive, txActive, txBit, porFlag, stopSeen;

  tuner_i2c_ctrl #(.ADDR_HI(ADDR_HI)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .rxByte(rxByte), .str(str), .ackDrive(ackDrive), .txActive(txActive),
    .stopSeen(stopSeen)
  );

  tuner_i2c_dp #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .lockIn(lockIn), .portLevels(portLevels),
    .adcCode(adcCode), .rxByte(rxByte), .txBit(txBit), .divRatio(divRatio),
    .cpHigh(cpHigh), .testMode(testMode), .cpDisable(cpDisable), .ampOff(ampOff),
    .portReg(portReg), .porFlag(porFlag)
  );

  assign sdaPullDown = ackDrive | (txActive & ~txBit);

  // R8: the power-on flag falls only after a STOP
  assert_por_clears_at_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(porFlag) |-> $past(stopSeen));
endmodule

// File: tb/test_tuner_i2c_slave.sv
module test_tuner_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;
  localparam logic [4:0] HI = 5'b11000;

  logic clk = 1'b0, rstN = 1'b0, scl = 1'b1, sdaM = 1'b1;
  logic sdaPullDown, sdaLine;
  logic [1:0] addrSel = 2'b00;
  logic lockIn = 1'b1;
  logic [2:0] portLevels = 3'b101, adcCode = 3'b011;
  logic [14:0] divRatio;
  logic cpHigh, testMode, cpDisable, ampOff;
  logic [7:0] portReg;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  assign sdaLine = sdaM & ~sdaPullDown;

  tuner_i2c_slave i_tuner_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaPullDown(sdaPullDown),
    .addrSel(addrSel), .lockIn(lockIn), .portLevels(portLevels), .adcCode(adcCode),
    .divRatio(divRatio), .cpHigh(cpHigh), .testMode(testMode), .cpDisable(cpDisable),
    .ampOff(ampOff), .portReg(portReg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clockBit(input logic b, output logic s);
    sdaM = b; waitQ();
    scl = 1'b1; waitQ();
    s = sdaLine; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    scl = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    scl = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recvByte(input logic masterAck, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      b[i] = s;
    end
    clockBit(~masterAck, s);
  endtask

  task automatic testReset();
    check("R10 divRatio", 16'(divRatio), 16'h0);
    check("R10 portReg", 16'(portReg), 16'h0);
    check("R10 ctrl bits", 16'({cpHigh, testMode, cpDisable, ampOff}), 16'h0);
    check("R10 sda released", 16'(sdaPullDown), 16'h0);
  endtask

  task automatic testWrongAddr();
    logic a;
    busStart();
    sendByte({HI, 2'b01, 1'b0}, a);
    check("R1 no ack on mismatch", 16'(a), 16'h0);
    sendByte(8'h12, a);
    sendByte(8'h34, a);
    busStop();
    check("R1 mismatch leaves ratio", 16'(divRatio), 16'h0);
  endtask

  task automatic testFreqPair();
    logic a;
    busStart();
    sendByte({HI, 2'b00, 1'b0}, a);
    check("R1 ack on match", 16'(a), 16'h1);
    sendByte(8'h12, a);
    check("R12 ack first byte", 16'(a), 16'h1);
    check("R2 ratio waits for second byte", 16'(divRatio), 16'h0);
    sendByte(8'h34, a);
    check("R12 ack second byte", 16'(a), 16'h1);
    check("R2 ratio", 16'(divRatio), 16'h1234);
    busStop();
  endtask

  task automatic testMultiPair();
    logic a;
    addrSel = 2'b10;
    busStart();
    sendByte({HI, 2'b10, 1'b0}, a);
    check("R1 ack with select 10", 16'(a), 16'h1);
    sendByte(8'hF1, a);
    check("R3 control fields", 16'({cpHigh, testMode, cpDisable, ampOff}), 16'hF);
    sendByte(8'hA5, a);
    check("R4 port byte", 16'(portReg), 16'hA5);
    sendByte(8'h05, a);
    sendByte(8'h67, a);
    check("R5 second pair ratio", 16'(divRatio), 16'h0567);
    check("R5 ports kept", 16'(portReg), 16'hA5);
    busStop();
  endtask

  task automatic testCutShort();
    logic a, s;
    busStart();
    sendByte({HI, 2'b10, 1'b0}, a);
    sendByte(8'h80, a);
    check("R3 control cleared", 16'({cpHigh, testMode, cpDisable, ampOff}), 16'h0);
    for (int i = 0; i < 4; i++) clockBit(1'b0, s);
    busStop();
    check("R6 ports kept after cut", 16'(portReg), 16'hA5);
    busStart();
    sendByte({HI, 2'b10, 1'b0}, a);
    sendByte(8'h7F, a);
    for (int i = 0; i < 4; i++) clockBit(1'b1, s);
    busStop();
    check("R6 ratio kept after cut", 16'(divRatio), 16'h0567);
  endtask

  task automatic testRepeatedStart();
    logic a;
    busStart();
    sendByte({HI, 2'b10, 1'b0}, a);
    sendByte(8'h81, a);
    check("R3 amp off alone", 16'({cpHigh, testMode, cpDisable, ampOff}), 16'h1);
    busStart();
    sendByte({HI, 2'b10, 1'b0}, a);
    check("R11 address after restart", 16'(a), 16'h1);
    sendByte(8'h00, a);
    sendByte(8'h02, a);
    check("R11 new pair after restart", 16'(divRatio), 16'h0002);
    check("R11 ports untouched", 16'(portReg), 16'hA5);
    busStop();
  endtask

  task automatic testRead();
    logic a;
    logic [7:0] b;
    busStart();
    sendByte({HI, 2'b10, 1'b1}, a);
    check("R1 read address ack", 16'(a), 16'h1);
    recvByte(1'b1, b);
    check("R7 R8 status with por after writes", 16'(b), 16'h00EB);
    recvByte(1'b0, b);
    check("R9 second status after ack", 16'(b), 16'h00EB);
    waitQ();
    check("R9 released after nack", 16'(sdaPullDown), 16'h0);
    busStop();
    lockIn = 1'b0; portLevels = 3'b010; adcCode = 3'b100;
    busStart();
    sendByte({HI, 2'b10, 1'b1}, a);
    recvByte(1'b0, b);
    check("R8 por cleared by read stop", 16'(b), 16'h0014);
    busStop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testWrongAddr();
    testFreqPair();
    testMultiPair();
    testCutShort();
    testRepeatedStart();
    testRead();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule